// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two predictors. The first is a table of 2-bit saturating counters indexed only by branch address. The second is a correlating table: each address-indexed row holds one 2-bit counter per value of a short global history of recent branch outcomes, and the current history picks the counter. A third table of 2-bit counters, also indexed by address, acts as a chooser between the two. It learns, for each address, which of the two predictors has been right more often.

A front end presents a fetch PC on the lookup port and gets the taken guess back in the same cycle. When a branch resolves, the back end presents its PC and real outcome on the update port. In the next clock edge the block trains all three tables and then shifts the outcome into the global history. An update and a lookup in the same cycle do not interact: the lookup sees the state from before that edge.

Top module: `tourney_pred`

## Requirements
- R1: Every counter is 2 bits wide and saturates. An update with outcome taken raises it by one, stopping at 11. An update with outcome not-taken lowers it by one, stopping at 00. A counter predicts taken when its upper bit is 1.
- R2: The address table is indexed by `lk_pc[PC_LSB +: BIM_IDX_W]` for a lookup and by `up_pc[PC_LSB +: BIM_IDX_W]` for an update. PCs that differ only outside those bits share one counter.
- R3: The correlating table row is indexed by `pc[PC_LSB +: COR_IDX_W]`, and the global history value picks one of the 2^HIST_W counters in that row. An update trains only the counter that the history held before that update picks.
- R4: A chooser entry (indexed by `pc[PC_LSB +: SEL_IDX_W]`) of 10 or 11 makes `lk_taken` the address table's guess. An entry of 00 or 01 makes it the correlating table's guess.
- R5: On each edge with `up_valid` high, the history becomes `{old_history[HIST_W-2:0], up_taken}`, with taken entering as 1 at bit 0. With `up_valid` low, the history is unchanged.
- R6: Synchronous active-high reset sets every address, correlating and chooser counter to 01 and the history to 00, so every lookup then predicts not-taken.
- R7: The chooser entry changes only when the two components' pre-update guesses for the updated branch differ. It moves one step toward 11 if the address table was right, and toward 00 if the correlating table was right.
- R8: `lk_taken` is a combinational function of `lk_pc` and the stored state. A change of `lk_pc` shows in the same cycle, and with no update the output for a fixed `lk_pc` holds.
- R9: An update reaches the state only at the clock edge. A lookup in the same cycle as an update returns the guess from the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Resolved branch present on the update port |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
On every cycle, the assertions check three things: that the history shifts in the outcome on an update and holds without one, that the output agrees with both components whenever they agree, and that the output holds while the PC and the state are still. Only the bench's scenarios can show the following. Counter saturation, aliasing between PCs that share index bits, training limited to the history-selected counter, chooser movement only on disagreement, and the one-cycle delay of an update against a same-cycle lookup all need a reference model over long update sequences. The bench compares against that model with random PCs drawn so that they collide in chosen index bits.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;

  // one saturating step of a 2-bit counter
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t n;
    if (up) n = (c == 2'b11) ? c : c + 2'b01;
    else    n = (c == 2'b00) ? c : c - 2'b01;
    return n;
  endfunction

endpackage

// File: rtl/sat_table.sv
module sat_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up,
  output ctr_t             old_ctr
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  assign rd_ctr  = mem[rd_idx];
  assign old_ctr = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(old_ctr, wr_up);
    end
  end

endmodule

// File: rtl/hist_reg.sv
module hist_reg #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
      end
    end
  endgenerate

endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int BIM_IDX_W = 10,
  parameter int COR_IDX_W = 9,
  parameter int SEL_IDX_W = 10,
  parameter int HIST_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);

  localparam int COR_TBL_W = COR_IDX_W + HIST_W;

  logic [HIST_W-1:0] ghr;

  logic [BIM_IDX_W-1:0] bim_lk_idx, bim_up_idx;
  logic [COR_TBL_W-1:0] cor_lk_idx, cor_up_idx;
  logic [SEL_IDX_W-1:0] sel_lk_idx, sel_up_idx;

  ctr_t bim_lk, cor_lk, sel_lk;
  ctr_t bim_old, cor_old, sel_old;

  logic comp_differ;
  logic bim_right;

  assign bim_lk_idx = lk_pc[PC_LSB +: BIM_IDX_W];
  assign bim_up_idx = up_pc[PC_LSB +: BIM_IDX_W];
  assign cor_lk_idx = {lk_pc[PC_LSB +: COR_IDX_W], ghr};
  assign cor_up_idx = {up_pc[PC_LSB +: COR_IDX_W], ghr};
  assign sel_lk_idx = lk_pc[PC_LSB +: SEL_IDX_W];
  assign sel_up_idx = up_pc[PC_LSB +: SEL_IDX_W];

  assign comp_differ = bim_old[1] ^ cor_old[1];
  assign bim_right   = (bim_old[1] == up_taken);

  sat_table #(.IDX_W(BIM_IDX_W)) u_bim (
    .clk(clk), .rst(rst),
    .rd_idx(bim_lk_idx), .rd_ctr(bim_lk),
    .wr_en(up_valid), .wr_idx(bim_up_idx), .wr_up(up_taken),
    .old_ctr(bim_old)
  );

  sat_table #(.IDX_W(COR_TBL_W)) u_cor (
    .clk(clk), .rst(rst),
    .rd_idx(cor_lk_idx), .rd_ctr(cor_lk),
    .wr_en(up_valid), .wr_idx(cor_up_idx), .wr_up(up_taken),
    .old_ctr(cor_old)
  );

  sat_table #(.IDX_W(SEL_IDX_W)) u_sel (
    .clk(clk), .rst(rst),
    .rd_idx(sel_lk_idx), .rd_ctr(sel_lk),
    .wr_en(up_valid & comp_differ), .wr_idx(sel_up_idx), .wr_up(bim_right),
    .old_ctr(sel_old)
  );

  hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst),
    .shift_en(up_valid), .bit_in(up_taken),
    .hist(ghr)
  );

  assign lk_taken = sel_lk[1] ? bim_lk[1] : cor_lk[1];

endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   lk_pc,
  input logic              lk_taken,
  input logic              up_valid,
  input logic              up_taken,
  input logic [HIST_W-1:0] ghr,
  input logic [1:0]        bim_lk,
  input logic [1:0]        cor_lk
);

  // R5: outcome enters at bit 0 on an update
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> ghr[0] == $past(up_taken));

  // R5: no update, history holds
  p_hist_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(ghr));

  // R4: when both components agree, the output follows them
  p_agree_out_r4: assert property (@(posedge clk) disable iff (rst)
    (bim_lk[1] == cor_lk[1]) |-> (lk_taken == bim_lk[1]));

  // R8: still PC and no update in the previous cycle, output holds
  p_lookup_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_taken));

endmodule

bind tourney_pred tourney_pred_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
  .up_valid(up_valid), .up_taken(up_taken), .ghr(ghr),
  .bim_lk(bim_lk), .cor_lk(cor_lk)
);

// File: tb/tb_tourney_pred.sv
module tb_tourney_pred;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int LSB    = 2;
  localparam int BW     = 10;
  localparam int CW     = 9;
  localparam int SW     = 10;
  localparam int HW     = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] lk_pc = '0;
  logic            lk_taken;
  logic            up_valid = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic            up_taken = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  logic [1:0]    m_bim [1<<BW];
  logic [1:0]    m_cor [1<<CW][1<<HW];
  logic [1:0]    m_sel [1<<SW];
  logic [HW-1:0] m_ghr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_pred dut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
  );

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic model_pred(input logic [PC_W-1:0] pc);
    logic [1:0] b, c, s;
    b = m_bim[pc[LSB +: BW]];
    c = m_cor[pc[LSB +: CW]][m_ghr];
    s = m_sel[pc[LSB +: SW]];
    return s[1] ? b[1] : c[1];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < (1<<BW); i++) m_bim[i] = 2'b01;
    for (int i = 0; i < (1<<SW); i++) m_sel[i] = 2'b01;
    for (int i = 0; i < (1<<CW); i++)
      for (int h = 0; h < (1<<HW); h++) m_cor[i][h] = 2'b01;
    m_ghr = '0;
  endtask

  task automatic model_update(input logic [PC_W-1:0] pc, input logic t);
    logic [1:0] b, c;
    b = m_bim[pc[LSB +: BW]];
    c = m_cor[pc[LSB +: CW]][m_ghr];
    if (b[1] != c[1]) m_sel[pc[LSB +: SW]] = sat(m_sel[pc[LSB +: SW]], b[1] == t);
    m_bim[pc[LSB +: BW]] = sat(b, t);
    m_cor[pc[LSB +: CW]][m_ghr] = sat(c, t);
    m_ghr = {m_ghr[HW-2:0], t};
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s lk_pc=%h actual=%0b expected=%0b", tag, lk_pc, act, exp);
    end
  endtask

  // one cycle: drive, check lookup against old model state, then clock
  task automatic step(input logic [PC_W-1:0] lpc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic ut, input string tag);
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    check(tag, lk_taken, model_pred(lpc));
    @(posedge clk);
    if (uv) model_update(upc, ut);
  endtask

  function automatic logic [PC_W-1:0] rand_pc();
    logic [PC_W-1:0] p;
    p = PC_W'($urandom % 16) << LSB;
    if ($urandom % 2) p[11] = 1'b1;  // splits address table, aliases correlating row
    if ($urandom % 2) p[12] = 1'b1;  // aliases every table
    return p;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R6: reset state predicts not-taken everywhere
    for (int k = 0; k < 4; k++) begin
      step(rand_pc(), 1'b0, '0, 1'b0, "R6 reset state");
      check("R6 reset literal", lk_taken, 1'b0);
    end

    // R9 / R7 / R4: branch A taken twice; chooser flips only on second update
    step(32'h0, 1'b1, 32'h0, 1'b1, "R7 agree no chooser move");
    check("R3 history-picked counter untrained", lk_taken, 1'b0);
    step(32'h0, 1'b1, 32'h0, 1'b1, "R9 same-cycle lookup old");
    check("R9 literal old state", lk_taken, 1'b0);
    step(32'h0, 1'b0, '0, 1'b0, "R4 chooser picks address table");
    check("R4 literal taken", lk_taken, 1'b1);
    // R2: full alias shares entries, bit 11 alias splits address table
    step(32'h1000, 1'b0, '0, 1'b0, "R2 alias shared");
    check("R2 literal shared", lk_taken, 1'b1);
    step(32'h800, 1'b0, '0, 1'b0, "R2 split address entry");

    // R1: saturate high then single not-taken keeps taken
    for (int k = 0; k < 6; k++) step(32'h40, 1'b1, 32'h40, 1'b1, "R1 saturate up");
    step(32'h40, 1'b1, 32'h40, 1'b0, "R1 step down");
    for (int k = 0; k < 6; k++) step(32'h40, 1'b1, 32'h40, 1'b0, "R1 saturate down");
    step(32'h40, 1'b0, '0, 1'b0, "R1 floor");

    // R5 / R3: alternating pattern exercises history-selected counters
    for (int k = 0; k < 40; k++) step(32'h80, 1'b1, 32'h80, k[0], "R5 R3 alternating");

    // R8: lookups without updates
    for (int k = 0; k < 20; k++) step(rand_pc(), 1'b0, '0, 1'b0, "R8 lookup only");

    // random mixed traffic
    for (int k = 0; k < 3000; k++)
      step(rand_pc(), ($urandom % 4) != 0, rand_pc(), $urandom % 3 != 0, "R7 R3 random");

    // R6: reset again clears trained state
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk) rst = 1'b0;
    step(32'h0, 1'b0, '0, 1'b0, "R6 reset after training");
    check("R6 literal after training", lk_taken, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule